// File: doc/BRIEF.md
# Multi-cycle instruction sequencer

This block is a small control core. It steps through a program of 16-bit instruction words held in a synchronous instruction memory. It keeps four 8-bit general registers and an 8-bit program counter. It reaches data memory through one synchronous byte port. Every instruction walks through fetch, decode and execute states. Most instructions then pass through one writeback state. Divide and remainder use an iterative unit, and the core waits in a stall state until that unit signals done. The halt opcode parks the core in a frozen state, and only reset brings it out.

Every word starts with a 6-bit opcode in bits 15:10. There are two layouts. The three-register layout holds a destination select in bits 9:8, a first source in bits 7:6, a second source in bits 5:4 and a 4-bit constant in bits 3:0. The constant layout holds a destination select in bits 9:8 and an 8-bit constant in bits 7:0.

Opcode values: 0 no-op, 1 add, 2 set constant, 3 branch if zero, 4 move, 5 store, 6 load, 7 subtract, 8 or, 9 and, 10 not, 11 xor, 12 add signed constant, 13 negate, 14 shift left, 15 logical shift right, 16 arithmetic shift right, 17 multiply, 18 divide, 19 remainder, 20 to 30 conditional branches, 31 jump to constant, 32 jump to register, 33 halt.

Top module: `seq_core`

## Requirements
- R1: While reset is low and after it is released, the PC is 0, all four registers are 0, `halted` is 0 and `dmem_we` is 0.
- R2: Bits 15:10 select the operation. The three-register layout places destination, source A and source B selects at 9:8, 7:6 and 5:4, with a 4-bit constant at 3:0. Opcode 2 writes bits 7:0 into the destination register.
- R3: A non-divide instruction takes exactly 4 clock cycles. `imem_addr` advances by one in each decode state. After reset, a program of N no-ops followed by a halt raises `halted` in clock edge 4N+3.
- R4: Opcode 4 copies source A into the destination. Opcode 5 drives `dmem_we` for one cycle, with address = source A and data = source B. Opcode 6 loads the destination from the byte at address source A.
- R5: Opcodes 1, 7, 8, 9, 10, 11, 13 and 17 compute A+B, A-B, A|B, A&B, ~A, A^B, -A and A*B, each modulo 256. Opcode 12 computes A plus the sign-extended 4-bit constant.
- R6: Opcodes 14, 15 and 16 shift A left, right with zero fill, or right with sign fill, by B taken as unsigned. When B is 8 or more, the result is 0, or all copies of the sign bit for opcode 16.
- R7: Opcodes 18 and 19 give the unsigned quotient and remainder of A by B. A divisor of 0 gives a quotient of 0xFF and a remainder of A. The instruction takes 13 cycles.
- R8: Conditional branches compare A with B (opcodes 20 to 25: ==, !=, <, <=, >, >=), or A with zero (3: ==0, 26: <0, 27: >0, 28: <=0, 29: >=0, 30: !=0). All comparisons are signed. A taken branch adds the sign-extended 4-bit constant to the PC that was already incremented.
- R9: Opcode 31 loads the PC with bits 7:0. Opcode 32 loads the PC from source A.
- R10: Opcode 33 sets `halted`. From then until reset, `imem_addr` does not move and `dmem_we` stays low.
- R11: Opcode 0 and opcodes 34 to 63 change no register and no memory, and only advance the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Instruction word address (the PC) |
| imem_rdata | input | 16 | Instruction word, registered by the memory one cycle after the address |
| dmem_addr | output | 8 | Data byte address |
| dmem_wdata | output | 8 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 8 | Load data, registered by the memory one cycle after the address |
| halted | output | 1 | Core stopped by the halt opcode |

## Verification
A wrong state in this core shows up mostly through the data port. A bad register value, a misdecoded field or a bad ALU result reaches memory at the next store, a few instructions later. A branch that goes the wrong way stores to a different address, or never reaches its halt. A slip in the state sequence changes how many cycles pass before `halted` rises. Each program is short, so any such fault appears within a few dozen cycles of reset release. For timing, the core checks its own PC step, its stall state and its halt freeze on the edge where they happen.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int DATA_W  = 8;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 6;
  localparam int RSEL_W  = 2;
  localparam int SH_W    = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [OPC_W-1:0]  opc_t;

  localparam opc_t OP_NOP  = 6'd0;
  localparam opc_t OP_ADD  = 6'd1;
  localparam opc_t OP_SETC = 6'd2;
  localparam opc_t OP_BZ   = 6'd3;
  localparam opc_t OP_MOV  = 6'd4;
  localparam opc_t OP_ST   = 6'd5;
  localparam opc_t OP_LD   = 6'd6;
  localparam opc_t OP_SUB  = 6'd7;
  localparam opc_t OP_OR   = 6'd8;
  localparam opc_t OP_AND  = 6'd9;
  localparam opc_t OP_NOT  = 6'd10;
  localparam opc_t OP_XOR  = 6'd11;
  localparam opc_t OP_ADDI = 6'd12;
  localparam opc_t OP_NEG  = 6'd13;
  localparam opc_t OP_SHL  = 6'd14;
  localparam opc_t OP_SHR  = 6'd15;
  localparam opc_t OP_SAR  = 6'd16;
  localparam opc_t OP_MUL  = 6'd17;
  localparam opc_t OP_DIV  = 6'd18;
  localparam opc_t OP_REM  = 6'd19;
  localparam opc_t OP_BEQ  = 6'd20;
  localparam opc_t OP_BNE  = 6'd21;
  localparam opc_t OP_BLT  = 6'd22;
  localparam opc_t OP_BLE  = 6'd23;
  localparam opc_t OP_BGT  = 6'd24;
  localparam opc_t OP_BGE  = 6'd25;
  localparam opc_t OP_BLTZ = 6'd26;
  localparam opc_t OP_BGTZ = 6'd27;
  localparam opc_t OP_BLEZ = 6'd28;
  localparam opc_t OP_BGEZ = 6'd29;
  localparam opc_t OP_BNZ  = 6'd30;
  localparam opc_t OP_JC   = 6'd31;
  localparam opc_t OP_JR   = 6'd32;
  localparam opc_t OP_HALT = 6'd33;

  // 4-bit constant widened with its sign bit
  function automatic word_t sext_c4(logic [3:0] c);
    return {{(DATA_W-4){c[3]}}, c};
  endfunction

  // shifter: an amount of DATA_W or more flushes the value
  function automatic word_t shift_op(opc_t op, word_t a, word_t n);
    logic flush;
    flush = (n >= word_t'(DATA_W));
    case (op)
      OP_SHL:  return flush ? '0 : (a << n[SH_W-1:0]);
      OP_SHR:  return flush ? '0 : (a >> n[SH_W-1:0]);
      default: return flush ? {DATA_W{a[DATA_W-1]}}
                            : word_t'($signed(a) >>> n[SH_W-1:0]);
    endcase
  endfunction

  // single-cycle results; unknown codes pass A through
  function automatic word_t alu_comb(opc_t op, word_t a, word_t b, logic [3:0] c);
    logic [2*DATA_W-1:0] prod;
    prod = a * b;
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_OR:   return a | b;
      OP_AND:  return a & b;
      OP_NOT:  return ~a;
      OP_XOR:  return a ^ b;
      OP_ADDI: return a + sext_c4(c);
      OP_NEG:  return word_t'(0) - a;
      OP_SHL, OP_SHR, OP_SAR: return shift_op(op, a, b);
      OP_MUL:  return prod[DATA_W-1:0];
      default: return a;
    endcase
  endfunction

  // {zero, sign, overflow} of a - b
  function automatic logic [2:0] cmp_flags(word_t a, word_t b);
    word_t d;
    d = a - b;
    return {(d == '0), d[DATA_W-1],
            (a[DATA_W-1] != b[DATA_W-1]) && (d[DATA_W-1] != a[DATA_W-1])};
  endfunction

  function automatic logic writes_reg(opc_t op);
    return (op == OP_ADD) || (op == OP_SETC) || (op == OP_MOV) ||
           (op == OP_LD) || ((op >= OP_SUB) && (op <= OP_REM));
  endfunction

  function automatic logic is_cond_branch(opc_t op);
    return (op == OP_BZ) || ((op >= OP_BEQ) && (op <= OP_BNZ));
  endfunction

  function automatic logic is_iter(opc_t op);
    return (op == OP_DIV) || (op == OP_REM);
  endfunction
endpackage

// File: rtl/seq_regfile.sv
module seq_regfile
  import seq_pkg::*;
#(
  parameter int NREGS = 4,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output word_t         rdata_a,
  output word_t         rdata_b
);
  word_t regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (waddr == AW'(g)))
        regs[g] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import seq_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem
);
  logic [DW-1:0] dvs;
  logic [CW-1:0] cnt;
  logic [DW:0]   shifted;
  logic          fits;

  // restoring step: bring in the next dividend bit, subtract if it fits
  assign shifted = {rem, quo[DW-1]};
  assign fits    = (shifted >= {1'b0, dvs});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      quo  <= '0;
      rem  <= '0;
      dvs  <= '0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        quo  <= dividend;
        rem  <= '0;
        dvs  <= divisor;
        cnt  <= CW'(DW);
      end else if (busy) begin
        rem  <= fits ? DW'(shifted - {1'b0, dvs}) : shifted[DW-1:0];
        quo  <= {quo[DW-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_div_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_div_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/seq_branch.sv
module seq_branch
  import seq_pkg::*;
(
  input  opc_t  op,
  input  word_t a,
  input  word_t b,
  output logic  take
);
  logic       vs_zero;
  word_t      rhs;
  logic [2:0] fl;
  logic       eq, lt;

  assign vs_zero = (op == OP_BZ) || (op >= OP_BLTZ);
  assign rhs     = vs_zero ? '0 : b;
  assign fl      = cmp_flags(a, rhs);
  assign eq      = fl[2];
  assign lt      = fl[1] ^ fl[0];

  always_comb begin
    case (op)
      OP_BZ, OP_BEQ:    take = eq;
      OP_BNE, OP_BNZ:   take = !eq;
      OP_BLT, OP_BLTZ:  take = lt;
      OP_BLE, OP_BLEZ:  take = lt || eq;
      OP_BGT, OP_BGTZ:  take = !lt && !eq;
      OP_BGE, OP_BGEZ:  take = !lt;
      default:          take = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [DATA_W-1:0]  dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               halted
);
  localparam int NREGS = 1 << RSEL_W;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_WAIT, S_WB, S_HALT
  } state_t;

  state_t               state;
  logic [PC_W-1:0]      pc;
  logic [INSTR_W-1:0]   ir;
  word_t                res_q;
  logic                 take_q;

  // instruction fields
  opc_t              f_op;
  logic [RSEL_W-1:0] f_ri, f_rj, f_rk;
  logic [3:0]        f_c4;
  logic [7:0]        f_c8;
  assign f_op = ir[15:10];
  assign f_ri = ir[9:8];
  assign f_rj = ir[7:6];
  assign f_rk = ir[5:4];
  assign f_c4 = ir[3:0];
  assign f_c8 = ir[7:0];

  // named internal events
  logic exec_evt, wb_evt, iter_start, iter_done, iter_busy, br_take, redirect, reg_we;
  word_t rj_val, rk_val, exec_res, wb_data, dq, dr;
  logic [PC_W-1:0] next_pc;

  assign exec_evt   = (state == S_EXEC);
  assign wb_evt     = (state == S_WB);
  assign iter_start = exec_evt && is_iter(f_op);
  assign reg_we     = wb_evt && writes_reg(f_op);
  assign wb_data    = (f_op == OP_LD) ? dmem_rdata : res_q;
  assign exec_res   = (f_op == OP_SETC) ? word_t'(f_c8) : alu_comb(f_op, rj_val, rk_val, f_c4);

  seq_regfile #(.NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .waddr   (f_ri),
    .wdata   (wb_data),
    .raddr_a (f_rj),
    .raddr_b (f_rk),
    .rdata_a (rj_val),
    .rdata_b (rk_val)
  );

  seq_divider #(.DW(DATA_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (iter_start),
    .dividend (rj_val),
    .divisor  (rk_val),
    .busy     (iter_busy),
    .done     (iter_done),
    .quo      (dq),
    .rem      (dr)
  );

  seq_branch u_br (
    .op   (f_op),
    .a    (rj_val),
    .b    (rk_val),
    .take (br_take)
  );

  // control transfer resolved in writeback
  always_comb begin
    redirect = 1'b0;
    next_pc  = pc;
    if (f_op == OP_JC) begin
      redirect = 1'b1;
      next_pc  = PC_W'(f_c8);
    end else if (f_op == OP_JR) begin
      redirect = 1'b1;
      next_pc  = PC_W'(res_q);
    end else if (is_cond_branch(f_op) && take_q) begin
      redirect = 1'b1;
      next_pc  = pc + {{(PC_W-4){f_c4[3]}}, f_c4};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_FETCH;
      pc     <= '0;
      ir     <= '0;
      res_q  <= '0;
      take_q <= 1'b0;
    end else begin
      case (state)
        S_FETCH:  state <= S_DECODE;
        S_DECODE: begin
          ir    <= imem_rdata;
          pc    <= pc + PC_W'(1);
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (f_op == OP_HALT)
            state <= S_HALT;
          else if (is_iter(f_op))
            state <= S_WAIT;
          else begin
            res_q  <= exec_res;
            take_q <= br_take;
            state  <= S_WB;
          end
        end
        S_WAIT: begin
          if (iter_done) begin
            res_q <= (f_op == OP_DIV) ? dq : dr;
            state <= S_WB;
          end
        end
        S_WB: begin
          if (redirect) pc <= next_pc;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = rj_val;
  assign dmem_wdata = rk_val;
  assign dmem_we    = exec_evt && (f_op == OP_ST);
  assign halted     = (state == S_HALT);

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE) |=> (imem_addr == $past(imem_addr) + PC_W'(1)));
  assert_store_in_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (state == S_EXEC) && !iter_busy);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !iter_done) |=> (state == S_WAIT));
  assert_iter_busy_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iter_busy |-> (state == S_WAIT));
  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(imem_addr));
  assert_halt_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !dmem_we);
endmodule

// File: tb/test_seq_core.sv
`timescale 1ns/1ps
module test_seq_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [15:0] imem_q;
  logic [7:0]  dmem_addr, dmem_wdata, dmem_q;
  logic        dmem_we, halted;

  logic [15:0] imem [256];
  logic [7:0]  dmem [256];

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int halt_wr = 0;

  always #2.5 clk = ~clk;

  seq_core i_seq_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_q),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_q),
    .halted     (halted)
  );

  always @(posedge clk) begin
    imem_q <= imem[imem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    dmem_q <= dmem[dmem_addr];
    if (halted && dmem_we) halt_wr <= halt_wr + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] w3(logic [5:0] op, logic [1:0] ri, logic [1:0] rj,
                                     logic [1:0] rk, logic [3:0] c);
    return {op, ri, rj, rk, c};
  endfunction
  function automatic logic [15:0] wc(logic [5:0] op, logic [1:0] ri, logic [7:0] c);
    return {op, ri, c};
  endfunction

  function automatic string tag_of(logic [5:0] op);
    case (op)
      6'd2:                         return "R2";
      6'd4, 6'd6:                   return "R4";
      6'd14, 6'd15, 6'd16:          return "R6";
      6'd18, 6'd19:                 return "R7";
      6'd32:                        return "R9";
      6'd0, 6'd40:                  return "R11";
      default: return ((op == 6'd3) || (op >= 6'd20 && op <= 6'd30)) ? "R8" : "R5";
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      imem[i] = 16'h0000;
      dmem[i] = 8'h00;
    end
  endtask

  task automatic run_prog(output int cycles);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n  = 1'b1;
    cycles = 0;
    while (!halted && cycles < 2000) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
  endtask

  // {opcode, A, B, const4, expected address, expected byte}
  localparam int NV = 41;
  localparam logic [41:0] VEC [NV] = '{
    {6'd1,  8'h70, 8'h95, 4'h0, 8'h41, 8'h05},
    {6'd7,  8'h10, 8'h20, 4'h0, 8'h41, 8'hF0},
    {6'd8,  8'hA0, 8'h0C, 4'h0, 8'h41, 8'hAC},
    {6'd9,  8'hF3, 8'h3C, 4'h0, 8'h41, 8'h30},
    {6'd10, 8'h5A, 8'h00, 4'h0, 8'h41, 8'hA5},
    {6'd11, 8'hFF, 8'h0F, 4'h0, 8'h41, 8'hF0},
    {6'd12, 8'h10, 8'h00, 4'hE, 8'h41, 8'h0E},
    {6'd12, 8'h7F, 8'h00, 4'h7, 8'h41, 8'h86},
    {6'd13, 8'h01, 8'h00, 4'h0, 8'h41, 8'hFF},
    {6'd14, 8'h81, 8'h03, 4'h0, 8'h41, 8'h08},
    {6'd14, 8'hFF, 8'h08, 4'h0, 8'h41, 8'h00},
    {6'd15, 8'h80, 8'h07, 4'h0, 8'h41, 8'h01},
    {6'd15, 8'hC3, 8'hFF, 4'h0, 8'h41, 8'h00},
    {6'd16, 8'h80, 8'h02, 4'h0, 8'h41, 8'hE0},
    {6'd16, 8'h80, 8'h09, 4'h0, 8'h41, 8'hFF},
    {6'd16, 8'h40, 8'h09, 4'h0, 8'h41, 8'h00},
    {6'd17, 8'h13, 8'h11, 4'h0, 8'h41, 8'h43},
    {6'd18, 8'hC8, 8'h07, 4'h0, 8'h41, 8'h1C},
    {6'd19, 8'hC8, 8'h07, 4'h0, 8'h41, 8'h04},
    {6'd18, 8'h2A, 8'h00, 4'h0, 8'h41, 8'hFF},
    {6'd19, 8'h2A, 8'h00, 4'h0, 8'h41, 8'h2A},
    {6'd18, 8'h05, 8'h09, 4'h0, 8'h41, 8'h00},
    {6'd4,  8'h3C, 8'h11, 4'h0, 8'h41, 8'h3C},
    {6'd2,  8'h00, 8'h00, 4'h3, 8'h41, 8'h63},
    {6'd0,  8'h12, 8'h34, 4'h0, 8'h41, 8'h55},
    {6'd40, 8'h12, 8'h34, 4'h0, 8'h41, 8'h55},
    {6'd20, 8'h05, 8'h05, 4'h1, 8'h40, 8'h55},
    {6'd21, 8'h05, 8'h05, 4'h1, 8'h41, 8'h55},
    {6'd22, 8'h80, 8'h7F, 4'h1, 8'h40, 8'h55},
    {6'd23, 8'h03, 8'h03, 4'h1, 8'h40, 8'h55},
    {6'd24, 8'h7F, 8'h80, 4'h1, 8'h40, 8'h55},
    {6'd24, 8'h02, 8'h03, 4'h1, 8'h41, 8'h55},
    {6'd25, 8'hFF, 8'hFE, 4'h1, 8'h40, 8'h55},
    {6'd26, 8'h80, 8'h00, 4'h1, 8'h40, 8'h55},
    {6'd27, 8'h00, 8'h05, 4'h1, 8'h41, 8'h55},
    {6'd28, 8'h00, 8'h05, 4'h1, 8'h40, 8'h55},
    {6'd29, 8'h7F, 8'h00, 4'h1, 8'h40, 8'h55},
    {6'd30, 8'h00, 8'h05, 4'h1, 8'h41, 8'h55},
    {6'd3,  8'h00, 8'h05, 4'h1, 8'h40, 8'h55},
    {6'd6,  8'h20, 8'h00, 4'h0, 8'h41, 8'h9D},
    {6'd32, 8'h06, 8'h00, 4'h0, 8'h40, 8'h55}
  };

  initial begin
    int cycles;
    int addr0;
    clear_mem();

    // R1: state while held in reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "imem_addr in reset", imem_addr, 0);
    chk("R1", "halted in reset", halted, 0);
    chk("R1", "dmem_we in reset", dmem_we, 0);

    // table of one-operation programs; the word under test sits at address 4
    for (int v = 0; v < NV; v++) begin
      logic [5:0] op;
      logic [7:0] a, b, ea, ev;
      logic [3:0] c;
      {op, a, b, c, ea, ev} = VEC[v];
      clear_mem();
      dmem[8'h20] = 8'h9D;
      imem[0] = wc(6'd2, 2'd1, a);
      imem[1] = wc(6'd2, 2'd2, b);
      imem[2] = wc(6'd2, 2'd0, 8'h40);
      imem[3] = wc(6'd2, 2'd3, 8'h55);
      imem[4] = w3(op, 2'd3, 2'd1, 2'd2, c);
      imem[5] = wc(6'd2, 2'd0, 8'h41);
      imem[6] = w3(6'd5, 2'd0, 2'd0, 2'd3, 4'h0);
      imem[7] = wc(6'd33, 2'd0, 8'h00);
      run_prog(cycles);
      chk(tag_of(op), $sformatf("vector %0d op %0d stored byte", v, op), dmem[ea], ev);
    end

    // R1: registers start at zero (store R3 to address R0)
    clear_mem();
    dmem[0] = 8'hEE;
    imem[0] = w3(6'd5, 2'd0, 2'd0, 2'd3, 4'h0);
    imem[1] = wc(6'd33, 2'd0, 8'h00);
    run_prog(cycles);
    chk("R1", "register contents after reset", dmem[0], 0);

    // R3: two no-ops then halt, halted seen after edge 11
    clear_mem();
    imem[2] = wc(6'd33, 2'd0, 8'h00);
    run_prog(cycles);
    chk("R3", "cycles to halted", cycles, 11);

    // R7: set, set, divide, halt -> 4 + 4 + 13 + 3
    clear_mem();
    imem[0] = wc(6'd2, 2'd1, 8'd200);
    imem[1] = wc(6'd2, 2'd2, 8'd7);
    imem[2] = w3(6'd18, 2'd3, 2'd1, 2'd2, 4'h0);
    imem[3] = wc(6'd33, 2'd0, 8'h00);
    run_prog(cycles);
    chk("R7", "cycles with divide", cycles, 24);

    // R9: jump over the word at address 1
    clear_mem();
    imem[0] = wc(6'd31, 2'd0, 8'd5);
    imem[1] = wc(6'd2, 2'd3, 8'h11);
    imem[5] = wc(6'd2, 2'd3, 8'h77);
    imem[6] = w3(6'd5, 2'd0, 2'd0, 2'd3, 4'h0);
    imem[7] = wc(6'd33, 2'd0, 8'h00);
    run_prog(cycles);
    chk("R9", "jump to constant", dmem[0], 8'h77);

    // R8: backward branch loop runs three times
    clear_mem();
    imem[0] = wc(6'd2, 2'd1, 8'd3);
    imem[1] = wc(6'd2, 2'd0, 8'h40);
    imem[2] = w3(6'd12, 2'd2, 2'd2, 2'd0, 4'h1);
    imem[3] = w3(6'd12, 2'd1, 2'd1, 2'd0, 4'hF);
    imem[4] = w3(6'd30, 2'd0, 2'd1, 2'd0, 4'hD);
    imem[5] = w3(6'd5, 2'd0, 2'd0, 2'd2, 4'h0);
    imem[6] = wc(6'd33, 2'd0, 8'h00);
    run_prog(cycles);
    chk("R8", "backward branch loop count", dmem[8'h40], 3);

    // R10: halt freezes the core
    addr0 = imem_addr;
    halt_wr = 0;
    imem[7] = w3(6'd5, 2'd0, 2'd0, 2'd2, 4'h0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R10", "halted held", halted, 1);
    chk("R10", "imem_addr frozen", imem_addr, addr0);
    chk("R10", "stores while halted", halt_wr, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule